// File: doc/BRIEF.md
# Early-Exit Vector Subtract Sequencer

This block walks a vector operation across element positions 0 up to VL-1, one element for each accepted operand beat. For every element it subtracts a scalar operand (captured at start) from the element value. From the signed difference it builds a 4-bit condition field that is always written back. A selectable stop test on that field may end the loop before the last element. When the loop stops early the vector length is rewritten to the count of elements kept. A mode bit, called the late-test bit here, decides whether the element that trips the test has its difference committed and counted (test after writeback) or dropped (test before writeback).

The block sits between an operand read port and a register write port. It owns neither. It asks for elements with a valid/ready handshake. It emits a result-write strobe with index and data and a condition-write strobe with index and field. When it finishes it pulses done with the new length. The maximum length is passed through unchanged, and the element step counter reads zero at completion.

The controller has three states. `S_IDLE` waits for start. It goes to `S_RUN` on start with a nonzero length, or straight to `S_DONE` on start with length zero. `S_RUN` handles one element per handshake. It goes to `S_DONE` when the stop test fires or after the last element, and otherwise stays and advances the index. `S_DONE` raises done for one cycle and always returns to `S_IDLE`.

Top module: `ffvec_seq`

## Requirements
- R1: Each processed element yields a condition field with bit 3 = difference less than zero, bit 2 = greater than zero, bit 1 = equal to zero, bit 0 = 0. The difference is element minus scalar, taken as a DATA_W-bit two's complement value.
- R2: Elements are consumed in index order, one per cycle with both elem_valid_i and elem_ready_o high. A written result carries res_idx_o equal to that index and res_data_o equal to element minus scalar.
- R3: With the late-test bit clear, the first element whose stop test fires gets no result write, and the new length equals its index.
- R4: With the late-test bit set, the first element whose stop test fires does get its result written, and the new length equals its index plus one.
- R5: The condition field is written on every accepted beat, including the stopping one, with crf_idx_o equal to the element index.
- R6: The stop selector codes are 0 = equal bit, 1 = less-than bit, 2 = less-than or equal bit, 3 = record form (uses the equal bit). A set invert bit complements the test.
- R7: If no element trips the test, all VL elements are written and the new length equals the input VL.
- R8: A start with VL = 0 raises done in the next cycle with new length 0, makes no writes and asks for no element.
- R9: done is a one-cycle pulse. new_vl_o stays stable while idle with no start. At done, step_o is 0 and maxvl_o equals the MAXVL given at start.
- R10: elem_ready_o is high only while elements are being processed. A start during a run or during done is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a vector pass (ignored while busy) |
| vl_i | input | VL_W | Vector length for the pass |
| maxvl_i | input | VL_W | Maximum vector length, passed through |
| stop_sel_i | input | 2 | Stop test selector |
| stop_inv_i | input | 1 | Invert the stop test |
| late_test_i | input | 1 | 1: test after writeback, 0: test before |
| scalar_i | input | DATA_W | Scalar subtrahend |
| elem_valid_i | input | 1 | Element operand valid |
| elem_data_i | input | DATA_W | Element operand value |
| elem_ready_o | output | 1 | Sequencer accepts an element |
| res_we_o | output | 1 | Result write strobe |
| res_idx_o | output | VL_W | Result element index |
| res_data_o | output | DATA_W | Result value |
| crf_we_o | output | 1 | Condition field write strobe |
| crf_idx_o | output | VL_W | Condition field element index |
| crf_o | output | 4 | Condition field |
| new_vl_o | output | VL_W | Rewritten vector length |
| maxvl_o | output | VL_W | Maximum vector length, unchanged |
| step_o | output | VL_W | Current element step |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Pass in progress |

## Verification
On the stopping beat, three things happen in one cycle. The condition write, the stop decision and, under the late-test bit, the result write all coincide, and the length rewrite follows at the same edge. The bench sweeps every selector, invert and late-test combination over generated vectors whose differences cross zero in both directions. Some runs stop on index 0, some on the last index, and some never stop. Each beat's strobes are compared with an arithmetic model. The second collision is a start pulse that lands while a pass is running. It is judged by confirming that the running pass keeps its length, order and final result.

// File: rtl/ffvec_pkg.sv
package ffvec_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        STOP_EQ  = 2'd0,
        STOP_LT  = 2'd1,
        STOP_LE  = 2'd2,
        STOP_REC = 2'd3
    } stop_sel_e;

    localparam int CF_LT = 3;
    localparam int CF_GT = 2;
    localparam int CF_EQ = 1;

endpackage

// File: rtl/ffvec_cmp.sv
module ffvec_cmp #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] elem_i,
    input  logic [DATA_W-1:0] scalar_i,
    output logic [DATA_W-1:0] diff_o,
    output logic [3:0]        cf_o
);
    import ffvec_pkg::*;

    logic zero_w;
    logic neg_w;

    always_comb begin
        diff_o = elem_i - scalar_i;
        zero_w = (diff_o == '0);
        neg_w  = diff_o[DATA_W-1];
        cf_o         = 4'b0000;
        cf_o[CF_LT]  = neg_w;
        cf_o[CF_GT]  = !neg_w && !zero_w;
        cf_o[CF_EQ]  = zero_w;
    end

endmodule

// File: rtl/ffvec_stop.sv
module ffvec_stop (
    input  logic [3:0] cf_i,
    input  logic [1:0] sel_i,
    input  logic       inv_i,
    output logic       stop_o
);
    import ffvec_pkg::*;

    logic raw_w;

    always_comb begin
        unique case (stop_sel_e'(sel_i))
            STOP_EQ:  raw_w = cf_i[CF_EQ];
            STOP_LT:  raw_w = cf_i[CF_LT];
            STOP_LE:  raw_w = cf_i[CF_LT] | cf_i[CF_EQ];
            STOP_REC: raw_w = cf_i[CF_EQ];
            default:  raw_w = 1'b0;
        endcase
        stop_o = raw_w ^ inv_i;
    end

endmodule

// File: rtl/ffvec_ctrl.sv
module ffvec_ctrl #(
    parameter int VL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [VL_W-1:0] vl_i,
    input  logic [VL_W-1:0] maxvl_i,
    input  logic [1:0]      sel_i,
    input  logic            inv_i,
    input  logic            late_i,
    input  logic            elem_valid_i,
    input  logic            stop_i,
    output logic [1:0]      sel_q_o,
    output logic            inv_q_o,
    output logic            cap_o,
    output logic            elem_ready_o,
    output logic            res_we_o,
    output logic            crf_we_o,
    output logic [VL_W-1:0] idx_o,
    output logic [VL_W-1:0] new_vl_o,
    output logic [VL_W-1:0] maxvl_o,
    output logic            done_o,
    output logic            busy_o
);
    import ffvec_pkg::*;

    localparam logic [VL_W-1:0] ONE = VL_W'(1);

    seq_state_e      state_q, state_nx;
    logic [VL_W-1:0] idx_q;
    logic [VL_W-1:0] vl_q;
    logic [VL_W-1:0] maxvl_q;
    logic [VL_W-1:0] new_vl_q;
    logic [1:0]      sel_q;
    logic            inv_q;
    logic            late_q;

    logic            beat_w;
    logic            last_w;

    assign beat_w = (state_q == S_RUN) && elem_valid_i;
    assign last_w = (idx_q == vl_q - ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_nx = (vl_i == '0) ? S_DONE : S_RUN;
            end
            S_RUN: begin
                if (beat_w && (stop_i || last_w)) state_nx = S_DONE;
            end
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // configuration and element index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            vl_q     <= '0;
            maxvl_q  <= '0;
            new_vl_q <= '0;
            sel_q    <= '0;
            inv_q    <= 1'b0;
            late_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        idx_q   <= '0;
                        vl_q    <= vl_i;
                        maxvl_q <= maxvl_i;
                        sel_q   <= sel_i;
                        inv_q   <= inv_i;
                        late_q  <= late_i;
                        if (vl_i == '0) new_vl_q <= '0;
                    end
                end
                S_RUN: begin
                    if (beat_w) begin
                        if (stop_i) begin
                            new_vl_q <= late_q ? idx_q + ONE : idx_q;
                            idx_q    <= '0;
                        end else if (last_w) begin
                            new_vl_q <= vl_q;
                            idx_q    <= '0;
                        end else begin
                            idx_q <= idx_q + ONE;
                        end
                    end
                end
                S_DONE:  ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        elem_ready_o = 1'b0;
        res_we_o     = 1'b0;
        crf_we_o     = 1'b0;
        done_o       = 1'b0;
        busy_o       = 1'b1;
        cap_o        = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy_o = 1'b0;
                cap_o  = start_i;
            end
            S_RUN: begin
                elem_ready_o = 1'b1;
                crf_we_o     = beat_w;
                res_we_o     = beat_w && (!stop_i || late_q);
            end
            S_DONE:  done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    assign idx_o    = idx_q;
    assign new_vl_o = new_vl_q;
    assign maxvl_o  = maxvl_q;
    assign sel_q_o  = sel_q;
    assign inv_q_o  = inv_q;

endmodule

// File: rtl/ffvec_seq.sv
module ffvec_seq #(
    parameter int DATA_W = 64,
    parameter int VL_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [VL_W-1:0]   maxvl_i,
    input  logic [1:0]        stop_sel_i,
    input  logic              stop_inv_i,
    input  logic              late_test_i,
    input  logic [DATA_W-1:0] scalar_i,
    input  logic              elem_valid_i,
    input  logic [DATA_W-1:0] elem_data_i,
    output logic              elem_ready_o,
    output logic              res_we_o,
    output logic [VL_W-1:0]   res_idx_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic              crf_we_o,
    output logic [VL_W-1:0]   crf_idx_o,
    output logic [3:0]        crf_o,
    output logic [VL_W-1:0]   new_vl_o,
    output logic [VL_W-1:0]   maxvl_o,
    output logic [VL_W-1:0]   step_o,
    output logic              done_o,
    output logic              busy_o
);

    logic [DATA_W-1:0] scalar_q;
    logic [DATA_W-1:0] diff_w;
    logic [3:0]        cf_w;
    logic              stop_w;
    logic [1:0]        sel_q_w;
    logic              inv_q_w;
    logic              cap_w;
    logic [VL_W-1:0]   idx_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     scalar_q <= '0;
        else if (cap_w) scalar_q <= scalar_i;
    end

    ffvec_cmp #(.DATA_W(DATA_W)) u_cmp (
        .elem_i   (elem_data_i),
        .scalar_i (scalar_q),
        .diff_o   (diff_w),
        .cf_o     (cf_w)
    );

    ffvec_stop u_stop (
        .cf_i   (cf_w),
        .sel_i  (sel_q_w),
        .inv_i  (inv_q_w),
        .stop_o (stop_w)
    );

    ffvec_ctrl #(.VL_W(VL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .vl_i         (vl_i),
        .maxvl_i      (maxvl_i),
        .sel_i        (stop_sel_i),
        .inv_i        (stop_inv_i),
        .late_i       (late_test_i),
        .elem_valid_i (elem_valid_i),
        .stop_i       (stop_w),
        .sel_q_o      (sel_q_w),
        .inv_q_o      (inv_q_w),
        .cap_o        (cap_w),
        .elem_ready_o (elem_ready_o),
        .res_we_o     (res_we_o),
        .crf_we_o     (crf_we_o),
        .idx_o        (idx_w),
        .new_vl_o     (new_vl_o),
        .maxvl_o      (maxvl_o),
        .done_o       (done_o),
        .busy_o       (busy_o)
    );

    assign res_idx_o  = idx_w;
    assign crf_idx_o  = idx_w;
    assign step_o     = idx_w;
    assign res_data_o = diff_w;
    assign crf_o      = cf_w;

endmodule

// File: rtl/ffvec_seq_chk.sv
module ffvec_seq_chk #(
    parameter int VL_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            done_o,
    input logic            busy_o,
    input logic            elem_ready_o,
    input logic            res_we_o,
    input logic [VL_W-1:0] res_idx_o,
    input logic            crf_we_o,
    input logic [VL_W-1:0] crf_idx_o,
    input logic [3:0]      crf_o,
    input logic [VL_W-1:0] new_vl_o,
    input logic [VL_W-1:0] step_o
);

    p_cf_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        crf_we_o |-> (crf_o[0] == 1'b0) && ($countones(crf_o[3:1]) == 1));

    p_res_with_cf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_we_o |-> crf_we_o && (res_idx_o == crf_idx_o));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_step_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (step_o == '0));

    p_newvl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(new_vl_o));

    p_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        elem_ready_o |-> busy_o && !done_o);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !res_we_o && !crf_we_o && !elem_ready_o);

endmodule

bind ffvec_seq ffvec_seq_chk #(.VL_W(VL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .done_o       (done_o),
    .busy_o       (busy_o),
    .elem_ready_o (elem_ready_o),
    .res_we_o     (res_we_o),
    .res_idx_o    (res_idx_o),
    .crf_we_o     (crf_we_o),
    .crf_idx_o    (crf_idx_o),
    .crf_o        (crf_o),
    .new_vl_o     (new_vl_o),
    .step_o       (step_o)
);

// File: tb/ffvec_seq_test.sv
`timescale 1ns/1ps
module ffvec_seq_test;

    localparam int DW = 64;
    localparam int VW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [VW-1:0] vl_i = '0;
    logic [VW-1:0] maxvl_i = '0;
    logic [1:0]    stop_sel_i = '0;
    logic          stop_inv_i = 1'b0;
    logic          late_test_i = 1'b0;
    logic [DW-1:0] scalar_i = '0;
    logic          elem_valid_i = 1'b0;
    logic [DW-1:0] elem_data_i = '0;
    logic          elem_ready_o, res_we_o, crf_we_o, done_o, busy_o;
    logic [VW-1:0] res_idx_o, crf_idx_o, new_vl_o, maxvl_o, step_o;
    logic [DW-1:0] res_data_o;
    logic [3:0]    crf_o;

    int n_chk = 0;
    int n_err = 0;
    longint ev[0:15];

    always #4 clk = ~clk;

    ffvec_seq #(.DATA_W(DW), .VL_W(VW)) uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        summary();
    end

    // runs one pass; inputs change 1 ns after posedge, outputs sampled at negedge
    task automatic run_case(input int vl, input int sel, input bit inv, input bit late,
                            input longint sc, input int bubble_at, input bit restart_mid);
        int  exp_vl;
        bit  stopped;
        vl_i = VW'(vl); maxvl_i = VW'(vl + 3); stop_sel_i = 2'(sel);
        stop_inv_i = inv; late_test_i = late; scalar_i = DW'(sc);
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        exp_vl = vl;
        stopped = 1'b0;
        for (int i = 0; i < vl && !stopped; i++) begin
            longint d;
            bit hit, stp;
            logic [3:0] ecf;
            if (i == bubble_at) begin
                elem_valid_i = 1'b0;
                @(negedge clk);
                chk(!res_we_o && !crf_we_o, "R2", "write during bubble", res_we_o, 0);
                @(posedge clk); #1;
            end
            d = ev[i] - sc;
            ecf = {d < 0, d > 0, d == 0, 1'b0};
            case (sel)
                0, 3: hit = ecf[1];
                1:    hit = ecf[3];
                default: hit = ecf[3] | ecf[1];
            endcase
            stp = hit ^ inv;
            elem_valid_i = 1'b1;
            elem_data_i = DW'(ev[i]);
            if (restart_mid && i == 1) begin
                start_i = 1'b1; vl_i = VW'(1); late_test_i = ~late;
            end
            @(negedge clk);
            chk(elem_ready_o == 1'b1, "R10", "ready in run", elem_ready_o, 1);
            chk(crf_we_o == 1'b1 && crf_idx_o == VW'(i), "R5", "cf write/index",
                crf_idx_o, i);
            chk(crf_o == ecf, "R1", "cf value", crf_o, ecf);
            if (stp && !late)
                chk(res_we_o == 1'b0, "R3", "failing result suppressed", res_we_o, 0);
            else if (stp)
                chk(res_we_o == 1'b1, "R4", "failing result written", res_we_o, 1);
            else
                chk(res_we_o == 1'b1 && res_data_o == DW'(d) && res_idx_o == VW'(i),
                    "R2", "result data", res_data_o, d);
            if (stp) begin
                stopped = 1'b1;
                exp_vl = late ? i + 1 : i;
            end
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        elem_valid_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b1, "R9", "done raised", done_o, 1);
        chk(!elem_ready_o, "R10", "no ready at done", elem_ready_o, 0);
        if (stopped)
            chk(new_vl_o == VW'(exp_vl), late ? "R4" : "R3", "new vl", new_vl_o, exp_vl);
        else
            chk(new_vl_o == VW'(exp_vl), "R7", "new vl no stop", new_vl_o, exp_vl);
        chk(step_o == '0 && maxvl_o == VW'(vl + 3), "R9", "step/maxvl at done",
            maxvl_o, vl + 3);
        @(posedge clk); #1;
        @(negedge clk);
        chk(!done_o && new_vl_o == VW'(exp_vl), "R9", "pulse ends, vl held", new_vl_o, exp_vl);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk(!done_o && !elem_ready_o && !res_we_o && !crf_we_o && new_vl_o == '0,
            "R8", "reset state", done_o, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // stated example, equal stop, both test placements (R3, R4, R6)
        ev[0] = 9; ev[1] = 8; ev[2] = 3; ev[3] = 4;
        run_case(4, 0, 1'b0, 1'b0, 3, -1, 1'b0);
        run_case(4, 0, 1'b0, 1'b1, 3, -1, 1'b0);
        run_case(4, 3, 1'b0, 1'b1, 3, 2, 1'b0);

        // no stop at all (R7)
        for (int i = 0; i < 16; i++) ev[i] = 10;
        run_case(6, 0, 1'b0, 1'b0, 3, -1, 1'b0);

        // start while busy ignored (R10)
        run_case(4, 1, 1'b0, 1'b0, 3, -1, 1'b1);

        // zero length (R8)
        vl_i = '0; maxvl_i = VW'(5); start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        @(negedge clk);
        chk(done_o && new_vl_o == '0 && !res_we_o && !crf_we_o && !elem_ready_o,
            "R8", "zero length", new_vl_o, 0);
        @(posedge clk); #1;

        // sweep of selector, invert and placement over generated vectors (R6)
        for (int seed = 0; seed < 6; seed++) begin
            for (int i = 0; i < 16; i++)
                ev[i] = longint'((seed * 7 + i * 5) % 9) - ((seed % 2) ? 2 : 0);
            for (int sel = 0; sel < 4; sel++)
                for (int inv = 0; inv < 2; inv++)
                    for (int late = 0; late < 2; late++)
                        run_case(1 + (seed + sel) % 8, sel, inv[0], late[0], 3,
                                 (seed == 2) ? 1 : -1, 1'b0);
        end
        // negative scalar, wide wrap check of the sign (R1)
        for (int i = 0; i < 16; i++) ev[i] = -5 + i;
        run_case(8, 2, 1'b1, 1'b0, -2, -1, 1'b0);
        summary();
    end

endmodule